// File: doc/BRIEF.md
# Two-Level Look-Ahead Block Adder

This block adds two unsigned binary operands and a carry-in, producing a sum of the same width and a carry-out. There is no clock: the result follows the operands combinationally. The width is a parameter that must be a multiple of four. Elaboration stops with an error for any other value.

The operands are cut into four-bit slices. Inside each slice, every internal carry is formed in parallel from per-bit generate (both operand bits set) and propagate (exactly one operand bit set) terms. From one slice to the next, the carry ripples. When the width holds five or more slices, the slices are grouped in fours. Each group forms a combined generate/propagate pair using the usual carry operator (G_hi + G_lo·P_hi, P_lo·P_hi). That pair produces the carry into the next group in a single step, so the carry does not have to ripple through all four slices. A trailing group may hold fewer than four slices.

Top module: `rbcla_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + c_i` for any operand values (default WIDTH = 64).
- R2: `c_o` equals bit WIDTH of `a_i + b_i + c_i`, which is the carry leaving the most significant bit.
- R3: When every bit position propagates (`a_i ^ b_i` all ones), `c_o` equals `c_i`. `sum_o` is all ones when `c_i` = 0 and all zeros when `c_i` = 1.
- R4: When both operands are all ones, `c_o` is 1 for either value of `c_i`. `sum_o` is all ones with bit 0 equal to `c_i`.
- R5: With five or more slices, the carry into each four-slice group, formed from the group's combined generate/propagate pair, equals the carry that ripples out of the preceding group's last slice.
- R6: With both operands zero, `sum_o` equals `c_i` zero-extended and `c_o` is 0.
- R7: A width of fewer than five slices (WIDTH = 16) uses a single level of slices with no grouping, and still meets R1 and R2.
- R8: A width whose last group is partial (WIDTH = 24: one full group plus two slices) meets R1 and R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum modulo 2^WIDTH |
| c_o | output | 1 | Carry out of the top bit |

## Verification
The hardest situation to reach from the ports is a carry that starts at bit 0 and has to travel through every slice and every group. This only happens when all positions propagate, which random operands almost never produce at 64 bits. Directed vectors create it: operand pairs that are bitwise complements (all-ones/all-zeros and alternating patterns) with both carry-in values. Random vectors with a fixed seed are added on top, so that mixed generate/propagate runs exercise the group look-ahead path at every group boundary.

// File: rtl/rbcla_pkg.sv
package rbcla_pkg;
   localparam int SLICE_W     = 4;
   localparam int GRP_SLICES  = 4;
   localparam int GRP_MIN_SLC = 5;

   typedef struct packed {
      logic g;
      logic p;
   } gp_t;

   // carry operator: hi is the more significant span
   function automatic gp_t gp_join(input gp_t hi, input gp_t lo);
      gp_t r;
      r.g = hi.g | (lo.g & hi.p);
      r.p = hi.p & lo.p;
      return r;
   endfunction
endpackage

// File: rtl/rbcla_bitgp.sv
module rbcla_bitgp #(
   parameter int W = 64
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] g_o,
   output logic [W-1:0] p_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign g_o[i] = a_i[i] & b_i[i];
      assign p_o[i] = a_i[i] ^ b_i[i];
   end
endmodule

// File: rtl/rbcla_slice.sv
module rbcla_slice
   import rbcla_pkg::*;
(
   input  logic [SLICE_W-1:0] g_i,
   input  logic [SLICE_W-1:0] p_i,
   input  logic               ci_i,
   output logic [SLICE_W-1:0] cv_o,
   output logic               co_o,
   output gp_t                grp_o
);
   gp_t b0, b1, b2, b3, lo, hi;

   // parallel carries inside the slice
   assign cv_o[0] = ci_i;
   assign cv_o[1] = g_i[0] | (p_i[0] & ci_i);
   assign cv_o[2] = g_i[1] | (p_i[1] & g_i[0]) | (p_i[1] & p_i[0] & ci_i);
   assign cv_o[3] = g_i[2] | (p_i[2] & g_i[1]) | (p_i[2] & p_i[1] & g_i[0])
                  | (p_i[2] & p_i[1] & p_i[0] & ci_i);
   assign co_o    = g_i[3] | (p_i[3] & g_i[2]) | (p_i[3] & p_i[2] & g_i[1])
                  | (p_i[3] & p_i[2] & p_i[1] & g_i[0])
                  | (p_i[3] & p_i[2] & p_i[1] & p_i[0] & ci_i);

   // slice group pair through the carry operator tree
   assign b0 = '{g: g_i[0], p: p_i[0]};
   assign b1 = '{g: g_i[1], p: p_i[1]};
   assign b2 = '{g: g_i[2], p: p_i[2]};
   assign b3 = '{g: g_i[3], p: p_i[3]};
   assign lo = gp_join(b1, b0);
   assign hi = gp_join(b3, b2);
   assign grp_o = gp_join(hi, lo);

   always_comb begin
      if (grp_o.p) begin
         assert_slice_pass_R3: assert (co_o == ci_i)
            else $error("slice with full propagate did not pass its carry");
      end
      if (grp_o.g) begin
         assert_slice_gen_R4: assert (co_o == 1'b1)
            else $error("slice with group generate lost its carry");
      end
   end
endmodule

// File: rtl/rbcla_chain.sv
module rbcla_chain
   import rbcla_pkg::*;
#(
   parameter int NSLC = 4
) (
   input  logic [SLICE_W*NSLC-1:0] g_i,
   input  logic [SLICE_W*NSLC-1:0] p_i,
   input  logic                    ci_i,
   output logic [SLICE_W*NSLC-1:0] cv_o,
   output logic                    co_o,
   output gp_t                     grp_o
);
   localparam int CW = SLICE_W * NSLC;

   logic [NSLC:0] link;
   gp_t           sgrp [NSLC];

   if (NSLC < 1) begin : g_bad
      $error("rbcla_chain needs at least one slice");
   end

   assign link[0] = ci_i;

   for (genvar s = 0; s < NSLC; s++) begin : g_slc
      rbcla_slice u_slc (
         .g_i   (g_i[s*SLICE_W +: SLICE_W]),
         .p_i   (p_i[s*SLICE_W +: SLICE_W]),
         .ci_i  (link[s]),
         .cv_o  (cv_o[s*SLICE_W +: SLICE_W]),
         .co_o  (link[s+1]),
         .grp_o (sgrp[s])
      );
   end

   assign co_o = link[NSLC];

   always_comb begin
      grp_o = sgrp[0];
      for (int s = 1; s < NSLC; s++) begin
         grp_o = gp_join(sgrp[s], grp_o);
      end
   end

   logic unused_w;
   assign unused_w = ^CW;
endmodule

// File: rtl/rbcla_adder.sv
module rbcla_adder
   import rbcla_pkg::*;
#(
   parameter int WIDTH = 64
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             c_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             c_o
);
   localparam int NSLC    = WIDTH / SLICE_W;
   localparam bit USE_GRP = (NSLC >= GRP_MIN_SLC);
   localparam int NGRP    = (NSLC + GRP_SLICES - 1) / GRP_SLICES;
   localparam int LAST_N  = NSLC - GRP_SLICES * (NGRP - 1);
   localparam int GRP_W   = SLICE_W * GRP_SLICES;

   if ((WIDTH < SLICE_W) || ((WIDTH % SLICE_W) != 0)) begin : g_width_chk
      $error("rbcla_adder: WIDTH must be a positive multiple of 4");
   end

   logic [WIDTH-1:0] g_w, p_w, cv_w;

   rbcla_bitgp #(.W(WIDTH)) u_gp (
      .a_i (a_i),
      .b_i (b_i),
      .g_o (g_w),
      .p_o (p_w)
   );

   if (!USE_GRP) begin : g_flat
      gp_t whole;
      rbcla_chain #(.NSLC(NSLC)) u_chain (
         .g_i   (g_w),
         .p_i   (p_w),
         .ci_i  (c_i),
         .cv_o  (cv_w),
         .co_o  (c_o),
         .grp_o (whole)
      );
      always_comb begin
         if (whole.p) begin
            assert_flat_pass_R3: assert (c_o == c_i)
               else $error("full-propagate operands did not pass the carry");
         end
      end
   end else begin : g_two_level
      logic [NGRP:0] gci;
      assign gci[0] = c_i;
      for (genvar k = 0; k < NGRP; k++) begin : g_grp
         localparam int NK = (k == NGRP - 1) ? LAST_N : GRP_SLICES;
         gp_t  ggrp;
         logic rip_co;
         rbcla_chain #(.NSLC(NK)) u_chain (
            .g_i   (g_w[k*GRP_W +: SLICE_W*NK]),
            .p_i   (p_w[k*GRP_W +: SLICE_W*NK]),
            .ci_i  (gci[k]),
            .cv_o  (cv_w[k*GRP_W +: SLICE_W*NK]),
            .co_o  (rip_co),
            .grp_o (ggrp)
         );
         // second-level look-ahead: group pair forms the next group carry
         assign gci[k+1] = ggrp.g | (ggrp.p & gci[k]);
         always_comb begin
            assert_grp_carry_R5: assert (gci[k+1] == rip_co)
               else $error("group look-ahead carry differs from rippled carry");
         end
      end
      assign c_o = gci[NGRP];
   end

   assign sum_o = p_w ^ cv_w;

   always_comb begin
      if ((a_i == '0) && (b_i == '0)) begin
         assert_zero_ops_R6: assert ((sum_o == WIDTH'(c_i)) && !c_o)
            else $error("zero operands gave a wrong result");
      end
   end
endmodule

// File: tb/rbcla_adder_test.sv
module rbcla_adder_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;  // 125 MHz

   logic [63:0] a, b;
   logic        ci;
   logic [63:0] s64;
   logic [15:0] s16;
   logic [23:0] s24;
   logic        c64, c16, c24;
   int errors = 0;
   int checks = 0;

   rbcla_adder #(.WIDTH(64)) uut (
      .a_i(a), .b_i(b), .c_i(ci), .sum_o(s64), .c_o(c64));
   rbcla_adder #(.WIDTH(16)) uut_n16 (
      .a_i(a[15:0]), .b_i(b[15:0]), .c_i(ci), .sum_o(s16), .c_o(c16));
   rbcla_adder #(.WIDTH(24)) uut_n24 (
      .a_i(a[23:0]), .b_i(b[23:0]), .c_i(ci), .sum_o(s24), .c_o(c24));

   function automatic logic [64:0] ref_add(input logic [63:0] x, input logic [63:0] y,
                                           input logic c, input int w);
      logic [64:0] m;
      m = (w == 64) ? {1'b0, {64{1'b1}}} : ((65'd1 << w) - 65'd1);
      return ({1'b0, x} & m) + ({1'b0, y} & m) + 65'(c);
   endfunction

   task automatic check(input bit ok, input string req, input logic [64:0] act,
                        input logic [64:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h (a=%h b=%h ci=%b)", req, act, exp, a, b, ci);
      end
   endtask

   task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic c,
                        input string tag);
      logic [64:0] e64, e16, e24;
      @(posedge clk);
      a = x; b = y; ci = c;
      @(negedge clk);
      e64 = ref_add(x, y, c, 64);
      e16 = ref_add(x, y, c, 16);
      e24 = ref_add(x, y, c, 24);
      check(s64 == e64[63:0], {"R1 sum ", tag}, {1'b0, s64}, {1'b0, e64[63:0]});
      check(c64 == e64[64], {"R2 carry ", tag}, 65'(c64), 65'(e64[64]));
      check({c16, s16} == e16[16:0], {"R7 w16 ", tag}, 65'({c16, s16}), 65'(e16[16:0]));
      check({c24, s24} == e24[24:0], {"R8 w24 ", tag}, 65'({c24, s24}), 65'(e24[24:0]));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      a = '0; b = '0; ci = 1'b0;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      // reset state: idle zero inputs give a zero result
      @(negedge clk);
      check((s64 == '0) && !c64, "R6 reset-state", {c64, s64}, 65'd0);
      rst = 1'b0;

      // R6: zero operands, both carry-in values
      apply('0, '0, 1'b0, "R6 zeros");
      check((s64 == 64'd0) && !c64, "R6 zero ci0", {c64, s64}, 65'd0);
      apply('0, '0, 1'b1, "R6 zeros");
      check((s64 == 64'd1) && !c64, "R6 zero ci1", {c64, s64}, 65'd1);

      // R3: every position propagates, carry crosses all slices and groups
      apply({64{1'b1}}, '0, 1'b1, "R3 prop");
      check((s64 == '0) && c64, "R3 full carry pass", {c64, s64}, {1'b1, 64'd0});
      apply({64{1'b1}}, '0, 1'b0, "R3 prop");
      check((s64 == '1) && !c64, "R3 no carry", {c64, s64}, {1'b0, {64{1'b1}}});
      apply({32{2'b01}}, {32{2'b10}}, 1'b1, "R3 alt");
      check((s64 == '0) && c64, "R3 alternating pass", {c64, s64}, {1'b1, 64'd0});
      apply({32{2'b10}}, {32{2'b01}}, 1'b0, "R3 alt");

      // R4: both operands all ones
      apply({64{1'b1}}, {64{1'b1}}, 1'b0, "R4 ones");
      check((s64 == {{63{1'b1}}, 1'b0}) && c64, "R4 ones ci0", {c64, s64},
            {1'b1, {63{1'b1}}, 1'b0});
      apply({64{1'b1}}, {64{1'b1}}, 1'b1, "R4 ones");
      check((s64 == '1) && c64, "R4 ones ci1", {c64, s64}, {1'b1, {64{1'b1}}});

      // R5 corners: a carry generated just below each group boundary
      for (int k = 1; k < 4; k++) begin
         apply((64'h1 << (16 * k - 1)) | ((64'h1 << (16 * k - 1)) - 64'd1),
               64'h1 << (16 * k - 1), 1'b0, "R5 boundary");
      end
      apply({32{2'b10}}, {32{2'b10}}, 1'b1, "R5 alt gen");
      apply(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 1'b0, "R5 split");

      // random mix with a fixed seed
      for (int n = 0; n < 400; n++) begin
         logic [63:0] x, y;
         x = {$urandom(), $urandom()};
         y = {$urandom(), $urandom()};
         if (n % 5 == 0) y = ~x ^ (64'h1 << ($urandom() % 64));
         apply(x, y, 1'($urandom()), "random");
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule